// File: doc/BRIEF.md
# Dual-Port Memory with Collision Arbitration and Write Blocking

This block is a two-port synchronous RAM with arbitration for the case where both ports open the same word in the same clock cycle. Each port has its own enable, write strobe, address, write data and read data. When both ports are enabled on one address, the arbiter lets one port through and drives an active-low busy line to the other port in the same cycle. A write from the port that lost is discarded inside the block. A read from that port still completes.

A mode input sets what the busy lines mean. In master mode the block arbitrates and drives its busy outputs actively in both states. In slave mode the block does no arbitration and holds its busy outputs inactive. Each port's busy input then acts only as a write-block control for that port. A master placed beside slaves of the same width can therefore feed its busy outputs into their busy inputs, so that every slice of a wide word drops the same write. The arbitration looks only at the enables and the addresses. The write strobes play no part in it.

Top module: `dpb_busy_ram`

## Requirements
- R1: During and after a synchronous active-high reset, both read data outputs are zero and both busy outputs are high.
- R2: In master mode, when both ports are enabled with equal addresses, the losing port's busy output goes low in that same cycle and the winner's stays high. With the default LEFT_WINS=1 the right port loses. The two busy outputs are never low together.
- R3: The collision decision ignores the write strobes: read/read, read/write and write/write collisions all raise busy in the same way.
- R4: Busy stays high on both ports when the addresses differ or when either port is disabled.
- R5: In master mode, a write from the losing port leaves memory unchanged, and the winner's write on that address lands.
- R6: A read from the losing port still returns the word's contents from before any write made in that cycle.
- R7: In slave mode, both busy outputs stay high even when both ports select the same address, and a write on that address from either port lands.
- R8: In slave mode, a port whose busy input is low (0) has its writes blocked. A port whose busy input is high (1) writes normally.
- R9: In master mode, the busy inputs have no effect: a port that wins, or that has no collision, writes even when its busy input is low.
- R10: Read data appears on the clock edge that follows the request (one cycle of latency). A port that writes and reads the same word gets the old contents (read-before-write).
- R11: A disabled port neither writes nor changes its read data output, whatever its write strobe does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| master_i | input | 1 | 1 = master mode (arbitrate), 0 = slave mode |
| l_ce | input | 1 | Left port enable |
| l_we | input | 1 | Left port write strobe |
| l_addr | input | ADDR_W | Left port address |
| l_wdata | input | DATA_W | Left port write data |
| l_rdata | output | DATA_W | Left port registered read data |
| l_busy_n_o | output | 1 | Left busy output, active low |
| l_busy_n_i | input | 1 | Left write-block input (slave mode), active low |
| r_ce | input | 1 | Right port enable |
| r_we | input | 1 | Right port write strobe |
| r_addr | input | ADDR_W | Right port address |
| r_wdata | input | DATA_W | Right port write data |
| r_rdata | output | DATA_W | Right port registered read data |
| r_busy_n_o | output | 1 | Right busy output, active low |
| r_busy_n_i | input | 1 | Right write-block input (slave mode), active low |

## Verification
The bench targets collisions in which the losing port writes. A design that failed to gate that write would let the right port's data overwrite the winner's, and the later read-back would show it. Read-only and read/write collisions confirm that busy does not depend on the write strobes, and that the losing port's read still returns the old word rather than nothing or the new data. Slave mode is run with colliding addresses, which must raise no busy, and with a busy input held low, which must block the write even though no collision exists. A busy input held low in master mode must be ignored. A disabled port with its write strobe raised must leave both its read data and memory untouched.

// File: rtl/dpb_pkg.sv
package dpb_pkg;
  typedef enum logic {
    MODE_SLAVE  = 1'b0,
    MODE_MASTER = 1'b1
  } dpb_mode_e;

  localparam int NUM_SIDES = 2;
  localparam int SIDE_L    = 0;
  localparam int SIDE_R    = 1;
endpackage

// File: rtl/dpb_conflict_arb.sv
module dpb_conflict_arb
  import dpb_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter bit LEFT_WINS = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  dpb_mode_e            mode,
  input  logic [NUM_SIDES-1:0] ce,
  input  logic [ADDR_W-1:0]    addr_l,
  input  logic [ADDR_W-1:0]    addr_r,
  output logic [NUM_SIDES-1:0] lose
);
  logic same_word;
  logic collide;

  // Only enables and addresses take part; write strobes are not inputs here.
  always_comb begin
    same_word = (addr_l == addr_r);
    collide   = (mode == MODE_MASTER) && ce[SIDE_L] && ce[SIDE_R] && same_word;
    lose      = '0;
    if (LEFT_WINS) lose[SIDE_R] = collide;
    else           lose[SIDE_L] = collide;
  end

  AST_SINGLE_LOSER: assert property (@(posedge clk) disable iff (rst)
    !(lose[SIDE_L] && lose[SIDE_R])); // R2

  AST_SLAVE_NO_ARB: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_SLAVE) |-> (lose == '0)); // R7

  AST_LOSS_NEEDS_CLASH: assert property (@(posedge clk) disable iff (rst)
    (lose != '0) |-> (ce == 2'b11 && addr_l == addr_r)); // R4
endmodule

// File: rtl/dpb_write_gate.sv
module dpb_write_gate
  import dpb_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  dpb_mode_e mode,
  input  logic      ce,
  input  logic      we,
  input  logic      lose,
  input  logic      busy_in_n,
  output logic      we_eff
);
  logic blocked;

  always_comb begin
    if (mode == MODE_MASTER) blocked = lose;
    else                     blocked = !busy_in_n;
    we_eff = ce && we && !blocked;
  end

  AST_SLAVE_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_SLAVE && !busy_in_n) |-> !we_eff); // R8

  AST_MASTER_PASS: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_MASTER && ce && we && !lose) |-> we_eff); // R9

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !ce |-> !we_eff); // R11
endmodule

// File: rtl/dpb_dp_store.sv
module dpb_dp_store #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_l,
  input  logic              ce_r,
  input  logic              wr_l,
  input  logic              wr_r,
  input  logic [ADDR_W-1:0] addr_l,
  input  logic [ADDR_W-1:0] addr_r,
  input  logic [DATA_W-1:0] wdata_l,
  input  logic [DATA_W-1:0] wdata_r,
  output logic [DATA_W-1:0] rdata_l,
  output logic [DATA_W-1:0] rdata_r
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Write array: plain synchronous writes, no reset, so block RAM can be inferred.
  always_ff @(posedge clk) begin
    if (wr_l) mem[addr_l] <= wdata_l;
    if (wr_r) mem[addr_r] <= wdata_r;
  end

  // Registered read ports, read-before-write.
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_l <= '0;
      rdata_r <= '0;
    end else begin
      if (ce_l) rdata_l <= mem[addr_l];
      if (ce_r) rdata_r <= mem[addr_r];
    end
  end

  AST_RD_HOLD_L: assert property (@(posedge clk) disable iff (rst)
    !ce_l |=> $stable(rdata_l)); // R11

  AST_RD_HOLD_R: assert property (@(posedge clk) disable iff (rst)
    !ce_r |=> $stable(rdata_r)); // R11
endmodule

// File: rtl/dpb_busy_ram.sv
module dpb_busy_ram
  import dpb_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 16,
  parameter bit LEFT_WINS = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              master_i,
  input  logic              l_ce,
  input  logic              l_we,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_busy_n_o,
  input  logic              l_busy_n_i,
  input  logic              r_ce,
  input  logic              r_we,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_busy_n_o,
  input  logic              r_busy_n_i
);
  dpb_mode_e            mode;
  logic [NUM_SIDES-1:0] ce_v;
  logic [NUM_SIDES-1:0] we_v;
  logic [NUM_SIDES-1:0] bin_v;
  logic [NUM_SIDES-1:0] lose;
  logic [NUM_SIDES-1:0] we_eff;

  assign mode  = dpb_mode_e'(master_i);
  assign ce_v  = {r_ce, l_ce};
  assign we_v  = {r_we, l_we};
  assign bin_v = {r_busy_n_i, l_busy_n_i};

  dpb_conflict_arb #(
    .ADDR_W    (ADDR_W),
    .LEFT_WINS (LEFT_WINS)
  ) u_arb (
    .clk    (clk),
    .rst    (rst),
    .mode   (mode),
    .ce     (ce_v),
    .addr_l (l_addr),
    .addr_r (r_addr),
    .lose   (lose)
  );

  // Busy outputs are always driven; in slave mode lose is zero so both sit high.
  assign l_busy_n_o = ~lose[SIDE_L];
  assign r_busy_n_o = ~lose[SIDE_R];

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_gate
    dpb_write_gate u_gate (
      .clk       (clk),
      .rst       (rst),
      .mode      (mode),
      .ce        (ce_v[s]),
      .we        (we_v[s]),
      .lose      (lose[s]),
      .busy_in_n (bin_v[s]),
      .we_eff    (we_eff[s])
    );
  end

  dpb_dp_store #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_store (
    .clk     (clk),
    .rst     (rst),
    .ce_l    (l_ce),
    .ce_r    (r_ce),
    .wr_l    (we_eff[SIDE_L]),
    .wr_r    (we_eff[SIDE_R]),
    .addr_l  (l_addr),
    .addr_r  (r_addr),
    .wdata_l (l_wdata),
    .wdata_r (r_wdata),
    .rdata_l (l_rdata),
    .rdata_r (r_rdata)
  );

  AST_NO_TWIN_WRITE: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_MASTER && we_eff == 2'b11) |-> (l_addr != r_addr)); // R5

  AST_BUSY_NOT_BOTH: assert property (@(posedge clk) disable iff (rst)
    (l_busy_n_o || r_busy_n_o)); // R2

  AST_LOSER_MUTED: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_MASTER && !r_busy_n_o) |-> !we_eff[SIDE_R]); // R5
endmodule

// File: tb/dpb_busy_ram_tb.sv
`timescale 1ns/1ps
module dpb_busy_ram_tb;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic master_i = 1'b1;
  logic l_ce = 0, l_we = 0, r_ce = 0, r_we = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic l_busy_n_i = 1'b1, r_busy_n_i = 1'b1;
  logic [DW-1:0] l_rdata, r_rdata;
  logic l_busy_n_o, r_busy_n_o;

  always #4 clk = ~clk;

  dpb_busy_ram #(.ADDR_W(AW), .DATA_W(DW), .LEFT_WINS(1'b1)) u_dut (
    .clk(clk), .rst(rst), .master_i(master_i),
    .l_ce(l_ce), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata),
    .l_rdata(l_rdata), .l_busy_n_o(l_busy_n_o), .l_busy_n_i(l_busy_n_i),
    .r_ce(r_ce), .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata),
    .r_rdata(r_rdata), .r_busy_n_o(r_busy_n_o), .r_busy_n_i(r_busy_n_i)
  );

  typedef struct {
    int          due;
    int          side;
    logic [DW-1:0] exp;
    string       tag;
  } item_t;

  item_t         sb[$];
  logic [DW-1:0] model [DEPTH];
  logic [DW-1:0] last_rd [2];
  int            cyc = 0;
  int            checks = 0;
  int            errors = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Monitor: compares read data on the cycle it is due.
  always @(posedge clk) begin
    #1;
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      it = sb.pop_front();
      chk(it.tag, (it.side == 0) ? l_rdata : r_rdata, it.exp);
    end
  end

  function automatic logic [DW-1:0] pat(input int i);
    return DW'(i * 263) ^ DW'(16'h5a5a);
  endfunction

  // Driver: applies one cycle on both ports, checks busy, queues expected reads, updates model.
  task automatic step(input logic m,
                      input logic lce, input logic lwe, input int la, input logic [DW-1:0] lwd, input logic lbi,
                      input logic rce, input logic rwe, input int ra, input logic [DW-1:0] rwd, input logic rbi,
                      input string tag);
    logic clash, lw_ok, rw_ok;
    logic [DW-1:0] lexp, rexp;
    @(negedge clk);
    master_i = m;
    l_ce = lce; l_we = lwe; l_addr = AW'(la); l_wdata = lwd; l_busy_n_i = lbi;
    r_ce = rce; r_we = rwe; r_addr = AW'(ra); r_wdata = rwd; r_busy_n_i = rbi;
    #1;
    clash = m && lce && rce && (la == ra);
    chk({tag, " left busy"}, DW'(l_busy_n_o), DW'(1'b1));
    chk({tag, " right busy"}, DW'(r_busy_n_o), DW'(!clash));
    lexp = lce ? model[la] : last_rd[0];
    rexp = rce ? model[ra] : last_rd[1];
    last_rd[0] = lexp;
    last_rd[1] = rexp;
    sb.push_back('{cyc + 1, 0, lexp, {tag, " left read"}});
    sb.push_back('{cyc + 1, 1, rexp, {tag, " right read"}});
    lw_ok = lce && lwe && (m ? 1'b1 : lbi);
    rw_ok = rce && rwe && (m ? !clash : rbi);
    if (lw_ok) model[la] = lwd;
    if (rw_ok) model[ra] = rwd;
  endtask

  task automatic idle(input string tag);
    step(1, 0, 0, 0, '0, 1, 0, 0, 0, '0, 1, tag);
  endtask

  initial begin
    last_rd[0] = '0;
    last_rd[1] = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 left rdata in reset", l_rdata, '0);
    chk("R1 right rdata in reset", r_rdata, '0);
    chk("R1 busy in reset", DW'({l_busy_n_o, r_busy_n_o}), DW'(2'b11));
    @(negedge clk);
    rst = 1'b0;
    idle("R1 after reset");

    // Fill memory from the left port (R10 latency checked on every step).
    for (int i = 0; i < DEPTH; i++)
      step(1, 1, 1, i, pat(i), 1, 0, 0, 0, '0, 1, "R10 fill");

    // Different addresses and single-port use: no busy.
    step(1, 1, 0, 5, '0, 1, 1, 0, 6, '0, 1, "R4 distinct reads");
    step(1, 1, 0, 7, '0, 1, 0, 0, 7, '0, 1, "R4 right idle same addr");
    step(1, 1, 1, 8, 16'h1111, 1, 1, 1, 9, 16'h2222, 1, "R4 two writes apart");
    step(1, 1, 0, 8, '0, 1, 1, 0, 9, '0, 1, "R4 readback");

    // Read-before-write on one port.
    step(1, 1, 1, 4, 16'hbeef, 1, 0, 0, 0, '0, 1, "R10 old data on write");
    step(1, 1, 0, 4, '0, 1, 0, 0, 0, '0, 1, "R10 new data after");

    // Write/write collision: right loses.
    step(1, 1, 1, 10, 16'haaaa, 1, 1, 1, 10, 16'h5555, 1, "R5 write clash");
    step(1, 0, 0, 0, '0, 1, 1, 0, 10, '0, 1, "R5 winner data kept");

    // Read/write collision with losing writer.
    step(1, 1, 0, 11, '0, 1, 1, 1, 11, 16'h7777, 1, "R3 read vs write clash");
    step(1, 1, 0, 11, '0, 1, 0, 0, 0, '0, 1, "R5 loser write dropped");

    // Read/read collision: busy still raised.
    step(1, 1, 0, 12, '0, 1, 1, 0, 12, '0, 1, "R3 read read clash");

    // Winner writes, loser reads: loser sees old word.
    step(1, 1, 1, 13, 16'hc0de, 1, 1, 0, 13, '0, 1, "R6 loser reads old");
    step(1, 0, 0, 0, '0, 1, 1, 0, 13, '0, 1, "R6 new word visible");

    // Master mode ignores busy inputs.
    step(1, 1, 1, 20, 16'h2020, 0, 1, 1, 21, 16'h2121, 0, "R9 busy in ignored");
    step(1, 1, 0, 20, '0, 1, 1, 0, 21, '0, 1, "R9 readback");

    // Slave mode.
    step(0, 1, 0, 14, '0, 1, 1, 0, 14, '0, 1, "R7 no busy on clash");
    step(0, 1, 1, 22, 16'h3333, 0, 1, 1, 23, 16'h4444, 1, "R8 left blocked right free");
    step(0, 1, 0, 22, '0, 1, 1, 0, 23, '0, 1, "R8 readback");
    step(0, 1, 0, 24, '0, 1, 1, 1, 24, 16'h6666, 1, "R7 write lands on clash");
    step(0, 1, 0, 24, '0, 1, 0, 0, 0, '0, 1, "R7 readback");

    // Disabled port with write strobe up.
    step(1, 0, 1, 25, 16'hdead, 1, 1, 0, 26, '0, 1, "R11 left disabled");
    step(1, 1, 0, 25, '0, 1, 0, 1, 26, 16'hfeed, 1, "R11 right disabled");
    step(1, 1, 0, 26, '0, 1, 1, 0, 25, '0, 1, "R11 memory untouched");

    idle("drain");
    idle("drain");
    @(posedge clk);
    #2;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule